// File: doc/BRIEF.md
# Byte/Word ROM Read Port with Identifier Mode

This block is a synthesizable behavioural model of a read-only memory read port. The memory holds 16-bit words. It can be read either as whole words or as 8-bit bytes. Two active-low controls gate the outputs. The chip select `sel_n` is the power control. The output gate `rd_n` decides whether data reaches the pins. The tri-state pins are modelled as a data vector plus a per-bit drive-enable vector.

In byte mode the upper eight output lanes are released. The pin that carries data bit 15 in word mode then becomes an input, and that input picks which half of the addressed word appears on the low lane.

An identifier mode returns two fixed codes instead of array data. It is entered with a high-voltage flag on address bit 9 while every other address bit except bit 0 is low. Address bit 0 picks between the two codes.

A program path exists so that a testbench can load contents. A program write can only clear bits to zero.

Read results pass through a register pipeline of `LAT` stages, which stands in for the access time.

Top module: `wordbyte_rom_port`

## Requirements
- R1: While `sel_n` is high (standby), the drive-enable vector `q_oe` is all zero, whatever `rd_n` is.
- R2: While `sel_n` is low and `rd_n` is high (output disable), `q_oe` is all zero.
- R3: Any bit of `q` whose enable in `q_oe` is 0 reads as 0.
- R4: In word mode (`word_mode`=1), with `sel_n`, `rd_n` and `prog_en` all low, `q_oe` is 16'hFFFF and `q` is the word at array index `addr[IDX_W-1:0]`.
- R5: In byte mode (`word_mode`=0), `q_oe` is never enabled on bits 15..8. A byte read drives `q_oe`=16'h00FF.
- R6: In a byte-mode read, `lsb_in`=1 places bits 15..8 of the addressed word on `q[7:0]`, and `lsb_in`=0 places bits 7..0 there.
- R7: When `hv_a9`=1 and address bits 15..10 and 8..1 are all 0, a read returns an identifier code. `addr[0]`=0 gives MFR_CODE (default 8'hC2) and `addr[0]`=1 gives DEV_CODE (default 8'h12). Word mode shows it as {8'h00, code}. Byte mode shows the code on `q[7:0]`, regardless of `lsb_in`.
- R8: When `hv_a9`=1 but any of address bits 15..10 or 8..1 is set, the read is a normal array read.
- R9: A program write happens at a clock edge where `prog_en`=1, `sel_n`=0 and `prog_we`=1. It stores the old word AND `prog_din`, so a bit that is 0 never returns to 1.
- R10: A program strobe with `sel_n` high leaves the array unchanged.
- R11: While `prog_en` is high, `q_oe` is all zero.
- R12: The outputs reflect the inputs sampled exactly `LAT` clock edges earlier (default 2). One edge sooner, the previous result is still shown.
- R13: Reset clears `q_oe` to zero and fills every array word with all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 16 | Word address |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Output gate, active low |
| word_mode | input | 1 | 1 = word reads, 0 = byte reads |
| lsb_in | input | 1 | Byte-mode lane select (the top data pin used as an input) |
| hv_a9 | input | 1 | High-voltage flag on address bit 9 |
| prog_en | input | 1 | Program mode |
| prog_we | input | 1 | Program write strobe |
| prog_din | input | 16 | Program data (zeros clear bits) |
| q | output | 16 | Output data |
| q_oe | output | 16 | Per-bit drive enable |

## Verification
The hardest case to reach from the ports is the identifier decode. It needs the flag together with a fully clear address apart from bit 0. Random addresses almost never produce that, and random addresses also rarely show the near-miss case where one stray bit must defeat the decode.

The stimulus therefore drives both codes directly in each width mode and with both lane selects. It then walks a single stray bit through every other address position with the flag raised. The AND-only program rule is driven by writing the same word twice with different data and reading it back. The random phase mixes program strobes, including inhibited ones, with reads, so that cleared bits build up over time.

// File: rtl/wordbyte_rom_port.sv
module wordbyte_rom_port #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int IDX_W = 6,
  parameter int LAT = 2,
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'h12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          sel_n,
  input  logic          rd_n,
  input  logic          word_mode,
  input  logic          lsb_in,
  input  logic          hv_a9,
  input  logic          prog_en,
  input  logic          prog_we,
  input  logic [DW-1:0] prog_din,
  output logic [DW-1:0] q,
  output logic [DW-1:0] q_oe
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int HB = DW / 2;
  localparam logic [AW-1:0] ID_FREE = AW'(1) | (AW'(1) << 9);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] pd [LAT];
  logic [DW-1:0] pe [LAT];

  wire [IDX_W-1:0] idx = addr[IDX_W-1:0];
  wire id_hit = hv_a9 && ((addr & ~ID_FREE) == '0);
  wire [7:0] id_code = addr[0] ? DEV_CODE : MFR_CODE;
  wire [DW-1:0] word_c = id_hit ? {{(DW-8){1'b0}}, id_code} : mem[idx];
  wire [HB-1:0] lane_c = id_hit ? HB'(id_code) :
                         (lsb_in ? word_c[DW-1:HB] : word_c[HB-1:0]);
  wire live = !sel_n && !rd_n && !prog_en;
  wire [DW-1:0] en_c = !live ? '0 : (word_mode ? '1 : {{HB{1'b0}}, {HB{1'b1}}});
  wire [DW-1:0] data_c = en_c & (word_mode ? word_c : {{HB{1'b0}}, lane_c});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (prog_en && !sel_n && prog_we) begin
      mem[idx] <= mem[idx] & prog_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        pd[i] <= '0;
        pe[i] <= '0;
      end
    end else begin
      pd[0] <= data_c;
      pe[0] <= en_c;
      for (int i = 1; i < LAT; i++) begin
        pd[i] <= pd[i-1];
        pe[i] <= pe[i-1];
      end
    end
  end

  assign q = pd[LAT-1];
  assign q_oe = pe[LAT-1];
endmodule

module wordbyte_rom_port_chk #(
  parameter int DW = 16,
  parameter int LAT = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_n,
  input logic          word_mode,
  input logic          prog_en,
  input logic [DW-1:0] q,
  input logic [DW-1:0] q_oe
);
  localparam int HB = DW / 2;
  logic [7:0] run_sb, run_by, run_pg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_sb <= '0;
      run_by <= '0;
      run_pg <= '0;
    end else begin
      run_sb <= sel_n ? ((run_sb == 8'hFF) ? run_sb : run_sb + 8'd1) : 8'd0;
      run_by <= !word_mode ? ((run_by == 8'hFF) ? run_by : run_by + 8'd1) : 8'd0;
      run_pg <= prog_en ? ((run_pg == 8'hFF) ? run_pg : run_pg + 8'd1) : 8'd0;
    end
  end

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(run_sb) >= LAT) |-> (q_oe == '0)); // R1
  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((q & ~q_oe) == '0)); // R3
  AST_UPPER_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(run_by) >= LAT) |-> (q_oe[DW-1:HB] == '0)); // R5
  AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_oe == '0) || (q_oe == '1) || (q_oe == {{HB{1'b0}}, {HB{1'b1}}})); // R5
  AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(run_pg) >= LAT) |-> (q_oe == '0)); // R11
endmodule

bind wordbyte_rom_port wordbyte_rom_port_chk #(.DW(DW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .word_mode(word_mode),
  .prog_en(prog_en), .q(q), .q_oe(q_oe));

// File: tb/sim_wordbyte_rom_port.sv
module sim_wordbyte_rom_port;
  localparam int LAT = 2;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic [15:0] addr = '0, prog_din = '0;
  logic sel_n = 1, rd_n = 1, word_mode = 1, lsb_in = 0, hv_a9 = 0, prog_en = 0, prog_we = 0;
  logic [15:0] q, q_oe;
  logic [15:0] sh [DEPTH];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wordbyte_rom_port #(.LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .rd_n(rd_n),
    .word_mode(word_mode), .lsb_in(lsb_in), .hv_a9(hv_a9), .prog_en(prog_en),
    .prog_we(prog_we), .prog_din(prog_din), .q(q), .q_oe(q_oe));

  function automatic logic [31:0] expect_out();
    logic [15:0] w, oe, d;
    logic [7:0] code;
    bit id;
    id = hv_a9 && addr[15:10] == 0 && addr[8:1] == 0;
    code = addr[0] ? 8'h12 : 8'hC2;
    w = id ? {8'h00, code} : sh[addr[5:0]];
    if (sel_n || rd_n || prog_en) begin
      oe = 0; d = 0;
    end else if (word_mode) begin
      oe = 16'hFFFF; d = w;
    end else begin
      oe = 16'h00FF;
      d = id ? {8'h00, code} : {8'h00, (lsb_in ? w[15:8] : w[7:0])};
    end
    return {oe, d};
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, logic [15:0] a, logic s, logic r, logic wm, logic l, logic h);
    logic [31:0] e;
    @(negedge clk);
    addr = a; sel_n = s; rd_n = r; word_mode = wm; lsb_in = l; hv_a9 = h;
    e = expect_out();
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    cmp(tag, {q_oe, q}, e);
  endtask

  task automatic pgm(logic [15:0] a, logic [15:0] dat, logic s);
    @(negedge clk);
    prog_en = 1; prog_we = 1; sel_n = s; addr = a; prog_din = dat; hv_a9 = 0;
    @(posedge clk);
    @(negedge clk);
    prog_we = 0; prog_en = 0;
    if (!s) sh[a[5:0]] = sh[a[5:0]] & dat;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] old_v, new_v;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) sh[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    cmp("R13 reset q_oe", {q_oe, q}, 32'h0);
    rst_n = 1;
    rd("R13 erased word", 16'd5, 0, 0, 1, 0, 0);

    pgm(16'd3, 16'hA55A, 0);
    rd("R4 word read", 16'd3, 0, 0, 1, 0, 0);
    rd("R6 byte low lane", 16'd3, 0, 0, 0, 0, 0);
    rd("R6 byte high lane", 16'd3, 0, 0, 0, 1, 0);
    rd("R5 byte enables", 16'd3, 0, 0, 0, 1, 0);
    rd("R1 standby rd low", 16'd3, 1, 0, 1, 0, 0);
    rd("R1 standby rd high", 16'd3, 1, 1, 0, 0, 0);
    rd("R2 output disable", 16'd3, 0, 1, 1, 0, 0);

    pgm(16'd7, 16'h00FF, 0);
    pgm(16'd7, 16'hFFF0, 0);
    rd("R9 no return to one", 16'd7, 0, 0, 1, 0, 0);
    pgm(16'd9, 16'h0000, 1);
    rd("R10 inhibited write", 16'd9, 0, 0, 1, 0, 0);

    rd("R7 mfr word", 16'h0000, 0, 0, 1, 0, 1);
    rd("R7 dev word", 16'h0001, 0, 0, 1, 0, 1);
    rd("R7 mfr byte", 16'h0000, 0, 0, 0, 1, 1);
    rd("R7 dev byte", 16'h0001, 0, 0, 0, 0, 1);
    rd("R7 bit9 ignored", 16'h0201, 0, 0, 1, 0, 1);
    for (int b = 1; b < 16; b++)
      if (b != 9) rd("R8 stray bit", 16'(1) << b, 0, 0, 1, 0, 1);

    @(negedge clk);
    prog_en = 1; sel_n = 0; rd_n = 0; addr = 16'd3; word_mode = 1;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    cmp("R11 prog quiet", {q_oe, q}, 32'h0);
    prog_en = 0;

    rd("R12 settle A", 16'd3, 0, 0, 1, 0, 0);
    old_v = {q_oe, q};
    @(negedge clk);
    addr = 16'd7;
    new_v = expect_out();
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    cmp("R12 old still shown", {q_oe, q}, old_v);
    @(posedge clk);
    @(negedge clk);
    cmp("R12 new after LAT", {q_oe, q}, new_v);

    for (int k = 0; k < 400; k++) begin
      logic [15:0] a;
      a = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % DEPTH);
      if ($urandom % 3 == 0)
        pgm(a, 16'($urandom) | 16'($urandom), ($urandom % 4 == 0));
      else
        rd("R4 R6 random read", a, ($urandom % 5 == 0), ($urandom % 5 == 0),
           1'($urandom), 1'($urandom), ($urandom % 8 == 0));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule